// File: doc/BRIEF.md
# Alarm Comparator and Interrupt Controller

This block sits beside the time-of-day counters of a real-time clock. It holds one alarm word per counter field: hundredths, hours, minutes, seconds, month, date, year and day of week. On every 100 Hz tick it compares the alarm words with the live counter values. When every field that takes part in the comparison is equal, it raises an alarm flag.

It also collects a flag for each counter increment and keeps a write-only mask at the same address as the read-only status. It drives an interrupt request when the global enable is on and a flag is set whose mask bit is also set.

Software reaches the block through a small register port with chip select, read and write strobes. Reading the status returns every flag and then clears all of them at the end of the read, which also releases the interrupt. While the chip is in standby, the register port is shut off. Flag collection and interrupt generation carry on.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, the status register (address 10h) reads 00h, every alarm word reads 00h, and irq_o is 0.
- R2: A pulse on inc_i[k] sets status bit k+1 on the next clock edge, whether or not the matching mask bit is set. The flags are: bit 1 hundredths, bit 2 tenths, bit 3 seconds, bit 4 minutes, bit 5 hours, bit 6 day. An unmasked flag leaves irq_o at 0.
- R3: Alarm word k is written and read back at address 08h+k. Field k of cnt_i (bits 8k+7..8k) is compared with alarm word k. The field order is hundredths, hours, minutes, seconds, month, date, year, day of week.
- R4: When tick_i is 1 and every alarm word with bit 7 clear equals its counter field (as an 8-bit value with bit 7 taken as 0), status bit 0 is set on that edge. A word with bit 7 set is left out of the comparison. The PM indicator (bit 6 of the hours field) takes part in the comparison.
- R5: An alarm hundredths word with bit 7 set behaves like a value of 00: the alarm can then fire only while the hundredths counter is 0. An alarm hundredths word with bit 7 clear is compared normally.
- R6: The alarm comparison only acts when tick_i is 1. A match that is held between ticks sets no flag.
- R7: irq_o and status bit 7 become 1 only if int_en_i is 1 while a status flag is set whose mask bit is also 1. The mask is written at address 10h, with bit 0 for the alarm and bits 1 to 6 for the periodic flags. Setting int_en_i later raises irq_o one edge after it goes to 1.
- R8: A read of address 10h returns {bit 7, flags}. On the clock edge where the read strobe ends, all status bits clear and irq_o drops to 0.
- R9: A flag event that arrives in the same cycle as the clearing edge is kept in the status register.
- R10: While standby_i is 1, writes have no effect and reads return 00h without clearing anything. Flags and irq_o keep working.
- R11: Writing the mask at address 10h leaves the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 100 Hz tick, high in the cycle after the counters are updated |
| inc_i | input | 6 | Increment pulses: hundredths, tenths, seconds, minutes, hours, day |
| cnt_i | input | 64 | Live counter fields, field k at bits 8k+7..8k |
| int_en_i | input | 1 | Global interrupt enable |
| standby_i | input | 1 | Standby; blocks register access |
| bus_cs_i | input | 1 | Chip select, active high |
| bus_rd_i | input | 1 | Read strobe, active high |
| bus_wr_i | input | 1 | Write strobe, active high |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while the read strobe is high |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The comparator is driven with a full match and then with one field changed at a time: a minute off by one, and the PM bit flipped in hours. These show that every enabled field counts and that the PM bit is part of the compare. It is also driven with ignored fields that hold arbitrary values. The hundredths field is tried ignored with a non-zero and a zero counter, and then compared for real. This separates "ignored means zero" from "ignored means don't care". A held match with no tick tells a per-tick evaluation apart from a level-sensitive one. The flag tests place a periodic event on the exact clearing edge, write the mask between a flag event and the read, and vary the enable and mask against standby to check the interrupt gating.

// File: rtl/rtc_alarm_irq_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_irq_pkg;
    localparam int FIELD_W_DEF     = 8;
    localparam int N_FIELDS_DEF    = 8;
    localparam int N_PERIODIC_DEF  = 6;
    localparam int ADDR_W_DEF      = 5;
    localparam int ALARM_BASE_DEF  = 8;
    localparam int STATUS_ADDR_DEF = 16;
    // field index whose ignore bit turns into a compare against zero
    localparam int HUND_IDX        = 0;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_ALARM  = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/rtc_alarm_bank.sv
`timescale 1ns/1ps
module rtc_alarm_bank
    import rtc_alarm_irq_pkg::*;
#(
    parameter int FIELD_W  = FIELD_W_DEF,
    parameter int N_FIELDS = N_FIELDS_DEF,
    localparam int IDX_W   = $clog2(N_FIELDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [FIELD_W-1:0]           wr_data_i,
    output logic [N_FIELDS*FIELD_W-1:0]  words_o
);
    typedef struct packed {
        logic [N_FIELDS-1:0][FIELD_W-1:0] word;
    } bank_state_t;

    bank_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            s_d.word[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign words_o = s_q.word;
endmodule

// File: rtl/rtc_alarm_matcher.sv
`timescale 1ns/1ps
module rtc_alarm_matcher
    import rtc_alarm_irq_pkg::*;
#(
    parameter int FIELD_W  = FIELD_W_DEF,
    parameter int N_FIELDS = N_FIELDS_DEF,
    localparam int CMP_W   = FIELD_W - 1
) (
    input  logic [N_FIELDS*FIELD_W-1:0] words_i,
    input  logic [N_FIELDS*FIELD_W-1:0] cnt_i,
    input  logic                        tick_i,
    output logic                        alarm_ev_o
);
    logic [N_FIELDS-1:0] field_eq;

    generate
        for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
            logic               ign;
            logic [FIELD_W-1:0] want;
            logic [FIELD_W-1:0] have;

            assign ign  = words_i[k*FIELD_W + CMP_W];
            assign want = {1'b0, words_i[k*FIELD_W +: CMP_W]};
            assign have = cnt_i[k*FIELD_W +: FIELD_W];

            if (k == HUND_IDX) begin : g_zero_when_ignored
                assign field_eq[k] = ign ? (have == '0) : (want == have);
            end else begin : g_skip_when_ignored
                assign field_eq[k] = ign | (want == have);
            end
        end
    endgenerate

    assign alarm_ev_o = tick_i & (&field_eq);
endmodule

// File: rtl/rtc_irq_flags.sv
`timescale 1ns/1ps
module rtc_irq_flags
    import rtc_alarm_irq_pkg::*;
#(
    parameter int N_PERIODIC = N_PERIODIC_DEF,
    localparam int FLAG_W    = N_PERIODIC + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PERIODIC-1:0] inc_i,
    input  logic                  alarm_ev_i,
    input  logic                  int_en_i,
    input  logic                  mask_we_i,
    input  logic [FLAG_W-1:0]     mask_wdata_i,
    input  logic                  clear_i,
    output logic [FLAG_W:0]       status_o,
    output logic                  irq_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] mask;
        logic [FLAG_W-1:0] flags;
        logic              glob;
    } flag_state_t;

    flag_state_t       s_d, s_q;
    logic [FLAG_W-1:0] events;
    logic [FLAG_W-1:0] kept;
    logic              glob_q;

    always_comb begin
        s_d    = s_q;
        events = {inc_i, alarm_ev_i};
        kept   = clear_i ? '0 : s_q.flags;
        if (mask_we_i) begin
            s_d.mask = mask_wdata_i;
        end
        s_d.flags = kept | events;
        s_d.glob  = (clear_i ? 1'b0 : s_q.glob)
                  | (int_en_i & (|(s_d.flags & s_q.mask)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign glob_q   = s_q.glob;
    assign status_o = {s_q.glob, s_q.flags};
    assign irq_o    = s_q.glob;

    // R2
    inc_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inc_i) |=> ((s_q.flags[FLAG_W-1:1] & $past(inc_i)) == $past(inc_i)));

    // R7
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_q) |-> $past(int_en_i));

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && (events == '0)) |=> ((s_q.flags == '0) && !glob_q));

    // R9
    event_survives_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && alarm_ev_i) |=> s_q.flags[0]);
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
module rtc_alarm_irq
    import rtc_alarm_irq_pkg::*;
#(
    parameter int FIELD_W     = FIELD_W_DEF,
    parameter int N_FIELDS    = N_FIELDS_DEF,
    parameter int N_PERIODIC  = N_PERIODIC_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int ALARM_BASE  = ALARM_BASE_DEF,
    parameter int STATUS_ADDR = STATUS_ADDR_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic [N_PERIODIC-1:0]       inc_i,
    input  logic [N_FIELDS*FIELD_W-1:0] cnt_i,
    input  logic                        int_en_i,
    input  logic                        standby_i,
    input  logic                        bus_cs_i,
    input  logic                        bus_rd_i,
    input  logic                        bus_wr_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [FIELD_W-1:0]          bus_wdata_i,
    output logic [FIELD_W-1:0]          bus_rdata_o,
    output logic                        irq_o
);
    localparam int IDX_W  = $clog2(N_FIELDS);
    localparam int FLAG_W = N_PERIODIC + 1;
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(ALARM_BASE);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(ALARM_BASE + N_FIELDS - 1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);

    typedef struct packed {
        logic rd_stat;
    } port_state_t;

    port_state_t               s_d, s_q;
    acc_kind_e                 kind;
    logic                      acc_ok;
    logic                      rd_stat_now;
    logic                      clear;
    logic [IDX_W-1:0]          idx;
    logic [N_FIELDS*FIELD_W-1:0] words;
    logic [FIELD_W-1:0]        word_arr [N_FIELDS];
    logic [FLAG_W:0]           status_w;
    logic                      alarm_ev;
    logic                      alarm_we;
    logic                      mask_we;

    generate
        for (genvar k = 0; k < N_FIELDS; k++) begin : g_unpack
            assign word_arr[k] = words[k*FIELD_W +: FIELD_W];
        end
    endgenerate

    always_comb begin
        s_d    = s_q;
        acc_ok = bus_cs_i & ~standby_i;
        idx    = IDX_W'(bus_addr_i - A_BASE);
        if ((bus_addr_i >= A_BASE) && (bus_addr_i <= A_LAST)) begin
            kind = ACC_ALARM;
        end else if (bus_addr_i == A_STAT) begin
            kind = ACC_STATUS;
        end else begin
            kind = ACC_NONE;
        end

        alarm_we    = acc_ok & bus_wr_i & (kind == ACC_ALARM);
        mask_we     = acc_ok & bus_wr_i & (kind == ACC_STATUS);
        rd_stat_now = acc_ok & bus_rd_i & (kind == ACC_STATUS);
        clear       = s_q.rd_stat & ~rd_stat_now;
        s_d.rd_stat = rd_stat_now;

        bus_rdata_o = '0;
        if (acc_ok & bus_rd_i) begin
            case (kind)
                ACC_ALARM:  bus_rdata_o = word_arr[idx];
                ACC_STATUS: bus_rdata_o = FIELD_W'(status_w);
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rtc_alarm_bank #(
        .FIELD_W  (FIELD_W),
        .N_FIELDS (N_FIELDS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (alarm_we),
        .wr_idx_i  (idx),
        .wr_data_i (bus_wdata_i),
        .words_o   (words)
    );

    rtc_alarm_matcher #(
        .FIELD_W  (FIELD_W),
        .N_FIELDS (N_FIELDS)
    ) u_match (
        .words_i    (words),
        .cnt_i      (cnt_i),
        .tick_i     (tick_i),
        .alarm_ev_o (alarm_ev)
    );

    rtc_irq_flags #(
        .N_PERIODIC (N_PERIODIC)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .inc_i        (inc_i),
        .alarm_ev_i   (alarm_ev),
        .int_en_i     (int_en_i),
        .mask_we_i    (mask_we),
        .mask_wdata_i (bus_wdata_i[FLAG_W-1:0]),
        .clear_i      (clear),
        .status_o     (status_w),
        .irq_o        (irq_o)
    );

    // R10
    standby_wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && bus_wr_i) |=> $stable(words));

    // R6
    alarm_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_w[0]) |-> $past(tick_i));
endmodule

// File: tb/rtc_alarm_irq_tb.sv
`timescale 1ns/1ps
module rtc_alarm_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  inc = '0;
    logic [63:0] cnt = '0;
    logic        int_en = 1'b0;
    logic        standby = 1'b0;
    logic        cs = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_irq u_dut (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .inc_i (inc), .cnt_i (cnt),
        .int_en_i (int_en), .standby_i (standby), .bus_cs_i (cs), .bus_rd_i (rd),
        .bus_wr_i (wr), .bus_addr_i (addr), .bus_wdata_i (wdata),
        .bus_rdata_o (rdata), .irq_o (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); cs = 1'b0; rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_inc(input logic [5:0] v);
        @(negedge clk); inc = v;
        @(negedge clk); inc = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic set_field(input int k, input logic [7:0] v);
        cnt[k*8 +: 8] = v;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(5'h10, d); check("R1 status after reset", d, 8'h00);
        bus_read(5'h08, d); check("R1 alarm word after reset", d, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_periodic();
        logic [7:0] d;
        int_en = 1'b1;
        pulse_inc(6'b000100);
        check("R2 unmasked flag keeps irq low", {7'b0, irq}, 8'h00);
        bus_read(5'h10, d); check("R2 seconds flag", d, 8'h08);
        pulse_inc(6'b100001);
        bus_read(5'h10, d); check("R2 day and hundredths flags", d, 8'h42);
        bus_read(5'h10, d); check("R8 cleared after read", d, 8'h00);
        int_en = 1'b0;
    endtask

    task automatic t_alarm();
        logic [7:0] d;
        logic [7:0] aw [8];
        aw[0] = 8'h80; aw[1] = 8'h45; aw[2] = 8'd30; aw[3] = 8'd15;
        aw[4] = 8'h80; aw[5] = 8'h80; aw[6] = 8'h80; aw[7] = 8'h80;
        for (int k = 0; k < 8; k++) bus_write(5'(8 + k), aw[k]);
        for (int k = 0; k < 8; k++) begin
            bus_read(5'(8 + k), d); check("R3 alarm readback", d, aw[k]);
        end
        set_field(0, 8'd0);  set_field(1, 8'h45); set_field(2, 8'd30); set_field(3, 8'd15);
        set_field(4, 8'd7);  set_field(5, 8'd21); set_field(6, 8'd24); set_field(7, 8'd3);
        pulse_tick();
        bus_read(5'h10, d); check("R4 full match with ignored fields", d, 8'h01);
        set_field(2, 8'd31);
        pulse_tick();
        bus_read(5'h10, d); check("R4 minute mismatch", d, 8'h00);
        set_field(2, 8'd30); set_field(1, 8'h05);
        pulse_tick();
        bus_read(5'h10, d); check("R4 PM bit mismatch", d, 8'h00);
        set_field(1, 8'h45); set_field(0, 8'd37);
        pulse_tick();
        bus_read(5'h10, d); check("R5 ignored hundredths needs zero", d, 8'h00);
        bus_write(5'h08, 8'd37);
        pulse_tick();
        bus_read(5'h10, d); check("R5 compared hundredths match", d, 8'h01);
        repeat (6) @(negedge clk);
        bus_read(5'h10, d); check("R6 held match without tick", d, 8'h00);
    endtask

    task automatic t_gating();
        logic [7:0] d;
        bus_write(5'h10, 8'h01);
        int_en = 1'b1;
        pulse_inc(6'b000010);
        check("R7 flag not in mask", {7'b0, irq}, 8'h00);
        int_en = 1'b0;
        pulse_tick();
        check("R7 enable off", {7'b0, irq}, 8'h00);
        @(negedge clk); int_en = 1'b1;
        @(negedge clk);
        check("R7 irq after enable", {7'b0, irq}, 8'h01);
        bus_read(5'h10, d); check("R7 status with global bit", d, 8'h85);
        check("R8 irq released", {7'b0, irq}, 8'h00);
        bus_read(5'h10, d); check("R8 status empty", d, 8'h00);
        bus_write(5'h10, 8'h00);
    endtask

    task automatic t_clear_race();
        logic [7:0] d;
        pulse_inc(6'b000001);
        @(negedge clk); cs = 1'b1; rd = 1'b1; addr = 5'h10;
        #1 d = rdata;
        @(negedge clk); cs = 1'b0; rd = 1'b0; inc = 6'b000100;
        @(negedge clk); inc = '0;
        check("R9 read before race", d, 8'h02);
        bus_read(5'h10, d); check("R9 event on clearing edge kept", d, 8'h08);
    endtask

    task automatic t_mask_write();
        logic [7:0] d;
        pulse_inc(6'b000001);
        bus_write(5'h10, 8'h00);
        bus_read(5'h10, d); check("R11 mask write keeps flags", d, 8'h02);
    endtask

    task automatic t_standby();
        logic [7:0] d;
        int_en = 1'b1;
        bus_write(5'h10, 8'h40);
        bus_read(5'h0F, d); check("R10 dow alarm before standby", d, 8'h80);
        @(negedge clk); standby = 1'b1;
        bus_write(5'h0F, 8'h12);
        bus_read(5'h0F, d); check("R10 read blocked", d, 8'h00);
        pulse_inc(6'b100000);
        check("R10 irq in standby", {7'b0, irq}, 8'h01);
        bus_read(5'h10, d); check("R10 status read blocked", d, 8'h00);
        @(negedge clk); standby = 1'b0;
        bus_read(5'h0F, d); check("R10 write ignored", d, 8'h80);
        bus_read(5'h10, d); check("R10 status kept through standby", d, 8'hC0);
        check("R8 irq cleared after standby", {7'b0, irq}, 8'h00);
        bus_write(5'h10, 8'h00);
        int_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_periodic();
        t_alarm();
        t_gating();
        t_clear_race();
        t_mask_write();
        t_standby();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule